// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block is a full-duplex serial port that moves 8-bit frames in both directions at once. It generates the serial clock itself and sends on one data line while it receives on another. Software reaches it through a small register bus. The bus holds a transmit byte, a received byte, a status byte, a control byte and a divider byte. Each data direction has a holding register in front of the shift logic. Software can therefore queue the next byte while the current frame is still on the wire.

Reading the received byte and writing a transmit byte update the status flags by themselves. When a frame finishes while the previous received byte has not been collected, an overrun flag is raised. From then on no frame starts in either direction until software acknowledges the error with a read-then-clear sequence. Clearing both enables stops the port, and this also aborts a frame that is under way.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status byte reads 0x01, the control byte reads 0x00, and `ser_clk` and `ser_out` are both 1. Register map on `bus_addr`:
  - 0: transmit byte.
  - 1: received byte.
  - 2: status, with bit0 = transmit empty, bit1 = receive full and bit2 = overrun.
  - 3: control, with bit0 = transmit enable and bit1 = receive enable.
  - 4: divider.
  - Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R2: Writing address 0 clears status bit0. Bit0 returns to 1 when the held byte is copied into the shifter at the start of a frame.
- R3: `ser_clk` idles high. `ser_out` changes with each falling edge and sends bit 0 first, 8 bits per frame. Each low and high phase lasts divider+1 system clocks.
- R4: `ser_in` is sampled on each rising edge, and the first sampled bit becomes bit 0. At frame end, with receive enabled, the byte is stored and status bit1 is set. Reading address 1 clears bit1.
- R5: If a frame ends while bit1 is already set and no address-1 read happens in that cycle, bit2 is set. The stored byte keeps its old value and the new frame is dropped.
- R6: While bit2 is 1, no frame starts, even with a transmit byte pending. Frames resume once bit2 is cleared.
- R7: Bit2 clears only when 0 is written to it after a status read that returned it as 1. Writing 1 to it, or writing 0 without that earlier read, leaves it set.
- R8: A transmit byte written during a frame is sent in the next frame. That frame's first falling edge comes divider+3 system clocks after the last rising edge of the previous frame.
- R9: With receive enabled and transmit disabled, a frame starts whenever bit1 is 0. `ser_out` stays 1, and no frame starts while bit1 is 1.
- R10: With receive disabled, frames still transmit, but status bit1 stays 0.
- R11: Clearing both enables during a frame returns `ser_clk` and `ser_out` to 1 on the next clock. The partial frame is not stored.
- R12: An address-1 read in the cycle a frame completes returns the old byte and stores the new one. Bit1 stays 1 and bit2 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_out | output | 1 | Serial transmit data |
| ser_in | input | 1 | Serial receive data |

## Verification
Two functions can fall in the same cycle: completion of a received frame and a software read of the received byte. The bench provokes this by counting rising edges of `ser_clk` on a frame that ends while the previous byte is still held. It then waits divider+1 clocks and issues the read in exactly the completion cycle. It passes only if three things hold: the read returns the earlier byte, the new byte is the next one read, and the overrun flag stays clear.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int ADR_TXD  = 0;
  localparam int ADR_RXD  = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_CTRL = 3;
  localparam int ADR_DIV  = 4;

  localparam int ST_TXE  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_OVR  = 2;

  localparam int CT_TXEN = 0;
  localparam int CT_RXEN = 1;
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] load,
  input  logic              abort,
  input  logic              tick,
  input  logic              ser_in,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ser_clk,
  output logic              ser_out
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              active_q, done_q, sck_q, sdo_q;
  logic [DATA_W-2:0] tsr_q;
  logic [DATA_W-1:0] rsr_q;
  logic [CNT_W-1:0]  bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      sck_q    <= 1'b1;
      sdo_q    <= 1'b1;
      tsr_q    <= '0;
      rsr_q    <= '0;
      bit_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        active_q <= 1'b0;
        sck_q    <= 1'b1;
        sdo_q    <= 1'b1;
      end else if (!active_q) begin
        if (start) begin
          active_q <= 1'b1;
          sck_q    <= 1'b0;
          sdo_q    <= load[0];
          tsr_q    <= load[DATA_W-1:1];
          bit_q    <= '0;
        end
      end else if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rsr_q <= {ser_in, rsr_q[DATA_W-1:1]};
        end else if (bit_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          sdo_q    <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          bit_q <= bit_q + 1'b1;
          sdo_q <= tsr_q[0];
          tsr_q <= tsr_q >> 1;
        end
      end
    end
  end

  assign active  = active_q;
  assign done    = done_q;
  assign rx_byte = rsr_q;
  assign ser_clk = sck_q;
  assign ser_out = sdo_q;

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (sck_q && sdo_q)); // R3
  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8
  AST_ABORT_RELEASES_CLOCK: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!active_q && sck_q)); // R11
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_clk,
  output logic              ser_out,
  input  logic              ser_in
);
  logic [DATA_W-1:0] tdr_q, rdr_q, rdata_q;
  logic              txe_q, rxf_q, ovr_q, ovr_armed_q;
  logic              txen_q, rxen_q;
  logic [DIV_W-1:0]  div_q;

  logic wr_txd, wr_stat, wr_ctrl, wr_div, rd_rxd, rd_stat;
  logic eng_active, eng_done, tick, start, abort, capture;
  logic [DATA_W-1:0] rx_byte, load;

  assign wr_txd  = bus_wr && (bus_addr == ADDR_W'(ADR_TXD));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign wr_div  = bus_wr && (bus_addr == ADDR_W'(ADR_DIV));
  assign rd_rxd  = bus_rd && (bus_addr == ADDR_W'(ADR_RXD));
  assign rd_stat = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));

  assign abort   = eng_active && !txen_q && !rxen_q;
  assign start   = !eng_active && !eng_done && !ovr_q &&
                   (txen_q ? !txe_q : (rxen_q && !rxf_q));
  assign load    = txen_q ? tdr_q : '1;
  assign capture = eng_done && rxen_q;

  ssp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(eng_active), .div(div_q), .tick(tick)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .load(load), .abort(abort),
    .tick(tick), .ser_in(ser_in), .active(eng_active), .done(eng_done),
    .rx_byte(rx_byte), .ser_clk(ser_clk), .ser_out(ser_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tdr_q       <= '0;
      rdr_q       <= '0;
      txe_q       <= 1'b1;
      rxf_q       <= 1'b0;
      ovr_q       <= 1'b0;
      ovr_armed_q <= 1'b0;
      txen_q      <= 1'b0;
      rxen_q      <= 1'b0;
      div_q       <= '0;
      rdata_q     <= '0;
    end else begin
      if (wr_txd) begin
        tdr_q <= bus_wdata;
        txe_q <= 1'b0;
      end else if (start && txen_q) begin
        txe_q <= 1'b1;
      end

      if (rd_stat && ovr_q) ovr_armed_q <= 1'b1;
      if (wr_stat && !bus_wdata[ST_OVR] && ovr_armed_q) begin
        ovr_q       <= 1'b0;
        ovr_armed_q <= 1'b0;
      end

      if (capture) begin
        if (rxf_q && !rd_rxd) begin
          ovr_q <= 1'b1;
        end else begin
          rdr_q <= rx_byte;
          rxf_q <= 1'b1;
        end
      end else if (rd_rxd) begin
        rxf_q <= 1'b0;
      end

      if (wr_ctrl) begin
        txen_q <= bus_wdata[CT_TXEN];
        rxen_q <= bus_wdata[CT_RXEN];
      end
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];

      if (bus_rd) begin
        case (bus_addr)
          ADDR_W'(ADR_TXD):  rdata_q <= tdr_q;
          ADDR_W'(ADR_RXD):  rdata_q <= rdr_q;
          ADDR_W'(ADR_STAT): rdata_q <= DATA_W'({ovr_q, rxf_q, txe_q});
          ADDR_W'(ADR_CTRL): rdata_q <= DATA_W'({rxen_q, txen_q});
          ADDR_W'(ADR_DIV):  rdata_q <= DATA_W'(div_q);
          default:           rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;

  AST_TXE_SET_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (start && txen_q && !wr_txd) |=> txe_q); // R2
  AST_RXF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_rxd && !eng_done) |=> !rxf_q); // R4
  AST_RXD_HELD_ON_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $stable(rdr_q)); // R5
  AST_NO_START_ON_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !eng_active) |=> !eng_active); // R6
  AST_OVR_WRITE_ONE_NOP: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && wr_stat && bus_wdata[ST_OVR]) |=> ovr_q); // R7
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ser_clk, ser_out;
  logic       ser_in = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sync_serial_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] slv(input int n);
    return 8'(8'h5A + n * 8'h27);
  endfunction

  int         mon_bits = 0;
  int         mon_frames = 0;
  logic [7:0] mon_shift = '0;
  logic [7:0] mon_last_tx = '0;
  logic [7:0] mon_last_slv = '0;

  always @(posedge ser_clk) begin
    if (!rst) begin
      mon_shift = {ser_out, mon_shift[7:1]};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_last_tx  = mon_shift;
        mon_last_slv = slv(mon_frames);
        mon_frames++;
        mon_bits = 0;
      end
    end
  end

  always @(negedge ser_clk) begin : slave_drive
    logic [7:0] t;
    if (!rst) begin
      t = slv(mon_frames);
      ser_in = t[mon_bits];
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_frame(input int target);
    while (mon_frames < target) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ser_clk idle", 8'(ser_clk), 8'h1);
    check("R1 ser_out idle", 8'(ser_out), 8'h1);
    bus_read(2, v); check("R1 status", v, 8'h01);
    bus_read(3, v); check("R1 control", v, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    int f, lows;
    bus_write(4, 8'd2);
    bus_write(0, 8'h3C);
    bus_read(2, v); check("R2 txe cleared by write", v, 8'h00);
    f = mon_frames;
    bus_write(3, 8'h03);
    for (int i = 0; i < 50 && ser_clk; i++) @(negedge clk);
    lows = 0;
    while (!ser_clk && lows < 50) begin lows++; @(negedge clk); end
    check("R3 low phase length", 8'(lows), 8'd3);
    wait_frame(f + 1);
    check("R3 lsb-first tx byte", mon_last_tx, 8'h3C);
    bus_read(2, v); check("R2 R4 status after frame", v, 8'h03);
    bus_read(1, v); check("R4 received byte", v, mon_last_slv);
    bus_read(2, v); check("R4 rxf cleared by read", v, 8'h01);
  endtask

  task automatic t_overrun();
    logic [7:0] v, save_a;
    int f;
    f = mon_frames;
    bus_write(0, 8'h11); wait_frame(f + 1);
    save_a = mon_last_slv;
    bus_write(0, 8'h22); wait_frame(f + 2);
    bus_write(2, 8'h00);
    bus_read(2, v); check("R5 R7 overrun set, unarmed clear ignored", v, 8'h07);
    bus_write(0, 8'h33);
    repeat (40) @(negedge clk);
    check("R6 no frame during overrun", 8'(mon_frames - f), 8'd2);
    bus_read(2, v); check("R6 tx byte still pending", v, 8'h06);
    bus_write(2, 8'h04);
    bus_read(2, v); check("R7 writing one keeps overrun", v, 8'h06);
    bus_read(1, v); check("R5 old byte kept", v, save_a);
    bus_write(2, 8'h00);
    wait_frame(f + 3);
    check("R6 transfer resumes", mon_last_tx, 8'h33);
    bus_read(2, v); check("R7 overrun cleared", v, 8'h03);
    bus_read(1, v); check("R6 resumed rx byte", v, mon_last_slv);
  endtask

  task automatic t_back_to_back();
    logic [7:0] v;
    logic prev;
    int rises, highs, f;
    bus_write(4, 8'd5);
    bus_write(3, 8'h00);
    f = mon_frames;
    bus_write(0, 8'hC3);
    bus_write(3, 8'h01);
    bus_write(0, 8'h96);
    prev = ser_clk; rises = 0;
    while (rises < 8) begin
      @(negedge clk);
      if (ser_clk && !prev) rises++;
      prev = ser_clk;
    end
    highs = 0;
    while (ser_clk && highs < 50) begin highs++; @(negedge clk); end
    check("R8 inter-frame high phase", 8'(highs), 8'd8);
    check("R8 first byte", mon_last_tx, 8'hC3);
    wait_frame(f + 2);
    check("R8 queued byte", mon_last_tx, 8'h96);
    bus_read(2, v); check("R10 rx disabled keeps rxf clear", v, 8'h01);
  endtask

  task automatic t_rx_only();
    logic [7:0] v;
    int f;
    bus_write(4, 8'd2);
    f = mon_frames;
    bus_write(3, 8'h02);
    wait_frame(f + 1);
    check("R9 ser_out held high", mon_last_tx, 8'hFF);
    bus_read(2, v); check("R9 rxf set", v, 8'h03);
    repeat (60) @(negedge clk);
    check("R9 no frame while full", 8'(mon_frames - f), 8'd1);
    bus_read(1, v); check("R9 received byte", v, mon_last_slv);
    while (mon_bits < 3) @(negedge clk);
    bus_write(3, 8'h00);
    @(negedge clk);
    check("R11 ser_clk after abort", 8'(ser_clk), 8'h1);
    check("R11 ser_out after abort", 8'(ser_out), 8'h1);
    repeat (20) @(negedge clk);
    bus_read(2, v); check("R11 partial frame not stored", v, 8'h01);
    mon_bits = 0; mon_shift = '0;
  endtask

  task automatic t_collide();
    logic [7:0] v, save_a;
    logic prev;
    int rises, f;
    bus_write(3, 8'h03);
    f = mon_frames;
    bus_write(0, 8'h5E); wait_frame(f + 1);
    save_a = mon_last_slv;
    bus_write(0, 8'hE5);
    prev = ser_clk; rises = 0;
    while (rises < 8) begin
      @(negedge clk);
      if (ser_clk && !prev) rises++;
      prev = ser_clk;
    end
    repeat (3) @(negedge clk);
    bus_addr = 3'd1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R12 read returns old byte", bus_rdata, save_a);
    repeat (4) @(negedge clk);
    bus_read(2, v); check("R12 rxf kept, no overrun", v, 8'h03);
    bus_read(1, v); check("R12 new byte stored", v, mon_last_slv);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mon_bits = 0; mon_frames = 0; mon_shift = '0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overrun();
    t_back_to_back();
    t_rx_only();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule